// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block runs the power-down mode of a small processor core. A one-cycle sleep strobe from the core starts power-down. The controller then updates the two status bits, pulses a clear to the watchdog timer and its postscaler, and turns the oscillator driver off. It keeps the core held until a wake condition arrives.

A wake condition is either an interrupt source whose flag and individual enable are both set, or a reset event. An interrupt wake is a continuation of execution. The global interrupt-disable bit never blocks it. That bit only selects whether the core carries on in line after the prefetched instruction, or runs that instruction and then branches to vector 0x0004. A reset event (power-on, brown-out, watchdog time-out or external reset) ends sleep as a full device reset.

In the two crystal oscillator modes, an interrupt wake first runs a start-up delay of 2^START_BITS oscillator cycles, 1024 by default, with the core still held. In RC mode the core resumes on the next cycle. The core reads the one-cycle wake action code to choose its next step.

Top module: `slp_wake_ctrl`

## Requirements
- R1: While rstN is low and just after it rises: pdBit=1, toBit=1, oscEnable=1, coreHold=0, wdtClear=0, wakeAction=2'b00.
- R2: sleepReq sampled while coreHold=0, with no reset event and no pending source, gives on the next cycle pdBit=0, toBit=1, oscEnable=0 and coreHold=1. It also gives wdtClear=1 for exactly that one cycle.
- R3: Source i is pending only when intFlags[i] and intEnables[i] are both 1. A flag without its enable leaves the block asleep (coreHold=1, oscEnable=0), and globalIntDis does not block a wake.
- R4: sleepReq sampled while a source is already pending wakes at once. On the next cycle pdBit=0, toBit=1, oscEnable=1, coreHold=0 and wdtClear=1, and the wake action code is issued.
- R5: An interrupt wake issues wakeAction=2'b01 (continue in line) when globalIntDis=1 in the issuing cycle, or 2'b10 (run the next instruction, then vector) when it is 0. The code lasts one cycle, and 2'b00 means no action.
- R6: With oscMode 2'b00 or 2'b01 (crystal), a wake detected at edge t gives oscEnable=1 and coreHold=1 from t+1 through t+1024. Hold is released and the action is issued at t+1025.
- R7: With oscMode 2'b10 or 2'b11 (RC), a wake detected at edge t releases coreHold and issues the action at t+1.
- R8: Every wake, interrupt or reset, raises wdtClear for one cycle on the cycle after it is detected.
- R9: A reset event (porEvt, borEvt, wdtTimeout or extRstEvt) in any state gives on the next cycle wakeAction=2'b11, coreHold=0, oscEnable=1 and wdtClear=1.
- R10: Status on reset events follows a fixed priority, porEvt/borEvt over wdtTimeout over extRstEvt. A power-on or brown-out sets pdBit=1 and toBit=1. A watchdog time-out clears toBit, and sets pdBit only if the core was running. An external reset leaves both bits unchanged.
- R11: sleepReq is ignored while coreHold=1 (asleep or in start-up). It causes no wdtClear pulse, no status change and no change to the start-up length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (oscillator periods) |
| rstN | input | 1 | Asynchronous active-low register reset |
| sleepReq | input | 1 | One-cycle strobe from the executed sleep instruction |
| intFlags | input | NUM_SRC | Per-source interrupt flags |
| intEnables | input | NUM_SRC | Per-source interrupt enables |
| globalIntDis | input | 1 | Global interrupt disable; selects the wake action only |
| porEvt | input | 1 | Power-on reset event |
| extRstEvt | input | 1 | External reset pin event |
| wdtTimeout | input | 1 | Watchdog time-out event |
| borEvt | input | 1 | Brown-out reset event |
| oscMode | input | 2 | 00/01 crystal modes, 10/11 RC modes |
| oscEnable | output | 1 | Oscillator driver enable |
| coreHold | output | 1 | Holds the core stopped |
| wdtClear | output | 1 | One-cycle clear for watchdog and postscaler |
| toBit | output | 1 | Time-out status bit |
| pdBit | output | 1 | Power-down status bit |
| wakeAction | output | 2 | 00 none, 01 in line, 10 vector after next, 11 reset |

## Verification
A wrong power state shows at once on oscEnable and coreHold, one cycle after the deciding edge. A lost start-up count shows up only when hold is released, up to 1025 cycles later, so the sweep measures the exact hold length for every mode. A corrupted status bit stays wrong until the next sleep or reset event. For that reason each status change is read back directly after the event that should cause it.

// File: rtl/slp_wake_pkg.sv
package slp_wake_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_INLINE = 2'b01,
    ACT_VECTOR = 2'b10,
    ACT_RESET  = 2'b11
  } wakeAct_e;

  typedef enum logic [1:0] {
    PS_RUN     = 2'b00,
    PS_SLEEP   = 2'b01,
    PS_STARTUP = 2'b10
  } pwrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sleepEntry;  // sleep accepted this cycle
    logic wakeStart;   // wake detected while asleep
    logic wakeIssue;   // interrupt wake completes, emit action
    logic cntRun;      // start-up counter advancing
    logic asleep;      // core not running
  } ctrlStrobe_t;

endpackage

// File: rtl/slp_wake_dp.sv
module slp_wake_dp
  import slp_wake_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int START_BITS = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] intFlags,
  input  logic [NUM_SRC-1:0] intEnables,
  input  logic               globalIntDis,
  input  logic               porEvt,
  input  logic               extRstEvt,
  input  logic               wdtTimeout,
  input  logic               borEvt,
  input  ctrlStrobe_t        strobe,
  output logic               wakePending,
  output logic               rstEvt,
  output logic               cntDone,
  output logic               pdBit,
  output logic               toBit,
  output logic               wdtClear,
  output logic [1:0]         wakeAction
);

  localparam logic [START_BITS-1:0] CNT_LAST = '1;

  logic [NUM_SRC-1:0]    srcWake;
  logic [START_BITS-1:0] startCnt;
  logic                  hardRst;
  logic                  wdtRst;
  logic                  extRst;
  wakeAct_e              actNext;

  // per-source wake qualification
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign srcWake[i] = intFlags[i] & intEnables[i];
  end
  assign wakePending = |srcWake;

  // reset event priority: power/brown-out, then watchdog, then pin
  assign hardRst = porEvt | borEvt;
  assign wdtRst  = wdtTimeout & ~hardRst;
  assign extRst  = extRstEvt & ~hardRst & ~wdtTimeout;
  assign rstEvt  = hardRst | wdtRst | extRst;

  // start-up delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startCnt <= '0;
    end else if (strobe.wakeStart) begin
      startCnt <= '0;
    end else if (strobe.cntRun && !cntDone) begin
      startCnt <= startCnt + 1'b1;
    end
  end
  assign cntDone = (startCnt == CNT_LAST);

  // status bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdBit <= 1'b1;
      toBit <= 1'b1;
    end else if (hardRst) begin
      pdBit <= 1'b1;
      toBit <= 1'b1;
    end else if (wdtRst) begin
      toBit <= 1'b0;
      if (!strobe.asleep) pdBit <= 1'b1;
    end else if (extRst) begin
      pdBit <= pdBit;
      toBit <= toBit;
    end else if (strobe.sleepEntry) begin
      pdBit <= 1'b0;
      toBit <= 1'b1;
    end
  end

  always_comb begin
    if (rstEvt)                actNext = ACT_RESET;
    else if (strobe.wakeIssue) actNext = globalIntDis ? ACT_INLINE : ACT_VECTOR;
    else                       actNext = ACT_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtClear   <= 1'b0;
      wakeAction <= ACT_NONE;
    end else begin
      wdtClear   <= rstEvt | strobe.sleepEntry | strobe.wakeStart;
      wakeAction <= actNext;
    end
  end

endmodule

// File: rtl/slp_wake_fsm.sv
module slp_wake_fsm
  import slp_wake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepReq,
  input  logic [1:0]  oscMode,
  input  logic        wakePending,
  input  logic        rstEvt,
  input  logic        cntDone,
  output ctrlStrobe_t strobe,
  output logic        oscEnable,
  output logic        coreHold
);

  pwrState_e state;
  pwrState_e stateNext;
  logic      crystal;

  assign crystal = (oscMode == 2'b00) || (oscMode == 2'b01);

  always_comb begin
    stateNext         = state;
    strobe            = '0;
    strobe.cntRun     = (state == PS_STARTUP);
    strobe.asleep     = (state != PS_RUN);
    if (rstEvt) begin
      stateNext = PS_RUN;
    end else begin
      unique case (state)
        PS_RUN: begin
          if (sleepReq) begin
            strobe.sleepEntry = 1'b1;
            if (wakePending) strobe.wakeIssue = 1'b1;
            else             stateNext = PS_SLEEP;
          end
        end
        PS_SLEEP: begin
          if (wakePending) begin
            strobe.wakeStart = 1'b1;
            if (crystal) begin
              stateNext = PS_STARTUP;
            end else begin
              stateNext        = PS_RUN;
              strobe.wakeIssue = 1'b1;
            end
          end
        end
        PS_STARTUP: begin
          if (cntDone) begin
            stateNext        = PS_RUN;
            strobe.wakeIssue = 1'b1;
          end
        end
        default: stateNext = PS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_RUN;
    else       state <= stateNext;
  end

  assign oscEnable = (state != PS_SLEEP);
  assign coreHold  = (state != PS_RUN);

endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
  import slp_wake_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int START_BITS = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleepReq,
  input  logic [NUM_SRC-1:0] intFlags,
  input  logic [NUM_SRC-1:0] intEnables,
  input  logic               globalIntDis,
  input  logic               porEvt,
  input  logic               extRstEvt,
  input  logic               wdtTimeout,
  input  logic               borEvt,
  input  logic [1:0]         oscMode,
  output logic               oscEnable,
  output logic               coreHold,
  output logic               wdtClear,
  output logic               toBit,
  output logic               pdBit,
  output logic [1:0]         wakeAction
);

  ctrlStrobe_t strobe;
  logic        wakePending;
  logic        rstEvt;
  logic        cntDone;

  slp_wake_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .sleepReq    (sleepReq),
    .oscMode     (oscMode),
    .wakePending (wakePending),
    .rstEvt      (rstEvt),
    .cntDone     (cntDone),
    .strobe      (strobe),
    .oscEnable   (oscEnable),
    .coreHold    (coreHold)
  );

  slp_wake_dp #(
    .NUM_SRC    (NUM_SRC),
    .START_BITS (START_BITS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .intFlags     (intFlags),
    .intEnables   (intEnables),
    .globalIntDis (globalIntDis),
    .porEvt       (porEvt),
    .extRstEvt    (extRstEvt),
    .wdtTimeout   (wdtTimeout),
    .borEvt       (borEvt),
    .strobe       (strobe),
    .wakePending  (wakePending),
    .rstEvt       (rstEvt),
    .cntDone      (cntDone),
    .pdBit        (pdBit),
    .toBit        (toBit),
    .wdtClear     (wdtClear),
    .wakeAction   (wakeAction)
  );

endmodule

// File: rtl/slp_wake_chk.sv
module slp_wake_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               sleepReq,
  input logic [NUM_SRC-1:0] intFlags,
  input logic [NUM_SRC-1:0] intEnables,
  input logic               globalIntDis,
  input logic               porEvt,
  input logic               extRstEvt,
  input logic               wdtTimeout,
  input logic               borEvt,
  input logic [1:0]         oscMode,
  input logic               oscEnable,
  input logic               coreHold,
  input logic               wdtClear,
  input logic               toBit,
  input logic               pdBit,
  input logic [1:0]         wakeAction
);

  logic pending;
  logic anyRst;
  logic rcMode;
  assign pending = |(intFlags & intEnables);
  assign anyRst  = porEvt | extRstEvt | wdtTimeout | borEvt;
  assign rcMode  = (oscMode == 2'b10) || (oscMode == 2'b11);

  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && !coreHold && !anyRst && !pending)
      |=> (!pdBit && toBit && wdtClear && !oscEnable && coreHold));

  a_r4_immediate_wake: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && !coreHold && !anyRst && pending)
      |=> (!coreHold && oscEnable && !pdBit && toBit && wdtClear &&
           wakeAction == ($past(globalIntDis) ? 2'b01 : 2'b10)));

  a_r5_inline_code: assert property (@(posedge clk) disable iff (!rstN)
    (wakeAction == 2'b01) |-> $past(globalIntDis));

  a_r5_vector_code: assert property (@(posedge clk) disable iff (!rstN)
    (wakeAction == 2'b10) |-> !$past(globalIntDis));

  a_r6_osc_when_running: assert property (@(posedge clk) disable iff (!rstN)
    !coreHold |-> oscEnable);

  a_r7_rc_wake: assert property (@(posedge clk) disable iff (!rstN)
    (coreHold && !oscEnable && pending && !anyRst && rcMode)
      |=> (!coreHold && wdtClear && wakeAction != 2'b00));

  a_r9_reset_action: assert property (@(posedge clk) disable iff (!rstN)
    anyRst |=> (wakeAction == 2'b11 && !coreHold && oscEnable && wdtClear));

  a_r10_hard_reset_status: assert property (@(posedge clk) disable iff (!rstN)
    (porEvt || borEvt) |=> (pdBit && toBit));

  a_r11_hold_keeps_status: assert property (@(posedge clk) disable iff (!rstN)
    (coreHold && !anyRst) |=> ($stable(pdBit) && $stable(toBit)));

endmodule

bind slp_wake_ctrl slp_wake_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .sleepReq     (sleepReq),
  .intFlags     (intFlags),
  .intEnables   (intEnables),
  .globalIntDis (globalIntDis),
  .porEvt       (porEvt),
  .extRstEvt    (extRstEvt),
  .wdtTimeout   (wdtTimeout),
  .borEvt       (borEvt),
  .oscMode      (oscMode),
  .oscEnable    (oscEnable),
  .coreHold     (coreHold),
  .wdtClear     (wdtClear),
  .toBit        (toBit),
  .pdBit        (pdBit),
  .wakeAction   (wakeAction)
);

// File: tb/tb_slp_wake_ctrl.sv
module tb_slp_wake_ctrl;

  localparam int NS   = 8;
  localparam int HOLD = 1024;

  logic          clk = 1'b0;
  logic          rstN;
  logic          sleepReq;
  logic [NS-1:0] intFlags;
  logic [NS-1:0] intEnables;
  logic          globalIntDis;
  logic          porEvt, extRstEvt, wdtTimeout, borEvt;
  logic [1:0]    oscMode;
  logic          oscEnable, coreHold, wdtClear, toBit, pdBit;
  logic [1:0]    wakeAction;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  slp_wake_ctrl #(.NUM_SRC(NS), .START_BITS(10)) dut (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .intFlags(intFlags),
    .intEnables(intEnables), .globalIntDis(globalIntDis), .porEvt(porEvt),
    .extRstEvt(extRstEvt), .wdtTimeout(wdtTimeout), .borEvt(borEvt),
    .oscMode(oscMode), .oscEnable(oscEnable), .coreHold(coreHold),
    .wdtClear(wdtClear), .toBit(toBit), .pdBit(pdBit), .wakeAction(wakeAction)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // enter sleep with nothing pending; checks R2 on the following cycle
  task automatic enterSleep(input logic [1:0] mode, input logic gid, input logic [NS-1:0] en);
    oscMode = mode; globalIntDis = gid; intEnables = en; intFlags = '0; sleepReq = 1'b1;
    tick();
    sleepReq = 1'b0;
    chk("R2", "pdBit", int'(pdBit), 0);
    chk("R2", "toBit", int'(toBit), 1);
    chk("R2", "wdtClear", int'(wdtClear), 1);
    chk("R2", "oscEnable", int'(oscEnable), 0);
    chk("R2", "coreHold", int'(coreHold), 1);
  endtask

  task automatic sendReset(input logic p, input logic e, input logic w, input logic b);
    porEvt = p; extRstEvt = e; wdtTimeout = w; borEvt = b;
    tick();
    porEvt = 0; extRstEvt = 0; wdtTimeout = 0; borEvt = 0;
    chk("R9", "action", int'(wakeAction), 3);
    chk("R9", "coreHold", int'(coreHold), 0);
    chk("R9", "oscEnable", int'(oscEnable), 1);
    chk("R8", "wdtClear on reset", int'(wdtClear), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    logic [NS-1:0] one;
    one = 1;
    rstN = 1'b0; sleepReq = 0; intFlags = '0; intEnables = '0; globalIntDis = 0;
    porEvt = 0; extRstEvt = 0; wdtTimeout = 0; borEvt = 0; oscMode = 2'b00;
    tick(); tick();
    // R1 reset state
    chk("R1", "pdBit", int'(pdBit), 1);
    chk("R1", "toBit", int'(toBit), 1);
    chk("R1", "oscEnable", int'(oscEnable), 1);
    chk("R1", "coreHold", int'(coreHold), 0);
    chk("R1", "wdtClear", int'(wdtClear), 0);
    chk("R1", "action", int'(wakeAction), 0);
    rstN = 1'b1;
    tick();
    chk("R1", "action after release", int'(wakeAction), 0);
    chk("R1", "coreHold after release", int'(coreHold), 0);

    // sweep: every mode, both global-disable values, every source
    for (int m = 0; m < 4; m++) begin
      for (int g = 0; g < 2; g++) begin
        for (int s = 0; s < NS; s++) begin
          int k;
          int expLen;
          enterSleep(2'(m), g[0], one << s);
          intFlags = ~(one << s);  // other flags set but not enabled
          tick();
          chk("R2", "wdtClear one cycle", int'(wdtClear), 0);
          tick(); tick();
          chk("R3", "no wake without enable", int'(coreHold), 1);
          chk("R3", "oscillator stays off", int'(oscEnable), 0);
          intFlags = '1;
          tick();
          intFlags = '0;
          chk("R8", "wdtClear on wake", int'(wdtClear), 1);
          chk("R6", "oscEnable after detect", int'(oscEnable), 1);
          k = 1;
          while (coreHold && k < 3000) begin
            tick();
            k++;
          end
          expLen = (m >= 2) ? 1 : HOLD + 1;
          chk(m >= 2 ? "R7" : "R6", "cycles to release", k, expLen);
          chk("R5", "action code", int'(wakeAction), g ? 1 : 2);
          tick();
          chk("R5", "action one cycle", int'(wakeAction), 0);
        end
      end
    end

    // R4 immediate wake, both global-disable values
    for (int g = 0; g < 2; g++) begin
      intEnables = 8'h10; intFlags = 8'h10; globalIntDis = g[0]; sleepReq = 1'b1;
      tick();
      sleepReq = 1'b0; intFlags = '0;
      chk("R4", "pdBit", int'(pdBit), 0);
      chk("R4", "toBit", int'(toBit), 1);
      chk("R4", "oscEnable", int'(oscEnable), 1);
      chk("R4", "coreHold", int'(coreHold), 0);
      chk("R4", "wdtClear", int'(wdtClear), 1);
      chk("R4", "action", int'(wakeAction), g ? 1 : 2);
      tick();
      chk("R5", "immediate action one cycle", int'(wakeAction), 0);
    end

    // R11 sleep request while asleep and during start-up
    begin
      int k;
      enterSleep(2'b00, 1'b0, 8'h01);
      tick();
      sleepReq = 1'b1;
      tick();
      sleepReq = 1'b0;
      chk("R11", "no clear while asleep", int'(wdtClear), 0);
      chk("R11", "still asleep", int'(coreHold), 1);
      intFlags = 8'h01;
      tick();
      intFlags = '0;
      k = 1;
      repeat (100) begin tick(); k++; end
      sleepReq = 1'b1;
      tick(); k++;
      sleepReq = 1'b0;
      chk("R11", "no clear in start-up", int'(wdtClear), 0);
      chk("R11", "pdBit unchanged", int'(pdBit), 0);
      chk("R11", "toBit unchanged", int'(toBit), 1);
      while (coreHold && k < 3000) begin tick(); k++; end
      chk("R11", "start-up length unchanged", k, HOLD + 1);
      chk("R11", "action after start-up", int'(wakeAction), 2);
      tick();
    end

    // R9/R10 reset events
    sendReset(0, 0, 1, 0);  // watchdog while running
    chk("R10", "wdt run toBit", int'(toBit), 0);
    chk("R10", "wdt run pdBit", int'(pdBit), 1);
    tick();
    chk("R9", "reset action one cycle", int'(wakeAction), 0);

    enterSleep(2'b10, 1'b0, 8'h02);
    sendReset(0, 0, 1, 0);  // watchdog while asleep
    chk("R10", "wdt sleep toBit", int'(toBit), 0);
    chk("R10", "wdt sleep pdBit", int'(pdBit), 0);
    tick();

    enterSleep(2'b01, 1'b1, 8'h02);
    sendReset(0, 1, 0, 0);  // external pin while asleep
    chk("R10", "ext toBit", int'(toBit), 1);
    chk("R10", "ext pdBit", int'(pdBit), 0);
    tick();

    enterSleep(2'b00, 1'b0, 8'h04);
    intFlags = 8'h04;
    tick();
    intFlags = '0;
    repeat (20) tick();
    chk("R6", "held in start-up", int'(coreHold), 1);
    sendReset(1, 0, 0, 0);  // power-on during start-up
    chk("R10", "por pdBit", int'(pdBit), 1);
    chk("R10", "por toBit", int'(toBit), 1);
    tick();

    sendReset(0, 1, 1, 0);  // watchdog outranks pin
    chk("R10", "wdt over ext toBit", int'(toBit), 0);
    sendReset(0, 0, 1, 1);  // brown-out outranks watchdog
    chk("R10", "bor over wdt toBit", int'(toBit), 1);
    chk("R10", "bor over wdt pdBit", int'(pdBit), 1);
    tick();

    summary();
  end

endmodule